// File: doc/BRIEF.md
# ADC Sample Limit and Rate-of-Change Monitor

This block watches a stream of unsigned ADC results. Each result arrives with a one-cycle valid strobe. The block keeps two status flags. The over-limit flag uses hysteresis. A result above a programmable ceiling sets it. Only a result below the ceiling minus a programmable margin releases it. The rate flag reports a step error. It latches when two accepted results in a row differ by more than a programmable step size. It then stays set until a clear pulse.

The monitor sits between an ADC result path and whatever status or interrupt logic reads the flags. The three thresholds are plain inputs that the surrounding logic holds steady. The monitor has no configuration state of its own, so a reset of the source registers to zero puts it in its idle setup. An enable level gates the whole block. While it is low, results are ignored and the step history is dropped.

Top module: `adc_limit_delta_monitor`

## Requirements
- R1: After reset, both `over_flag` and `step_flag` are 0, and no previous sample is held.
- R2: An accepted sample (`smp_valid`=1 and `enable`=1) that is strictly greater than `cfg_ceiling` sets `over_flag`; a sample equal to `cfg_ceiling` does not set it.
- R3: While `over_flag` is set, an accepted sample strictly less than the release level (`cfg_ceiling` − `cfg_margin`) clears it; a sample equal to the release level leaves it set.
- R4: An accepted sample between the release level and `cfg_ceiling` (both inclusive) leaves `over_flag` unchanged.
- R5: When `cfg_margin` ≥ `cfg_ceiling`, the release level saturates at 0 instead of wrapping, so no sample can release `over_flag`.
- R6: An accepted sample whose unsigned absolute difference from the previous accepted sample is strictly greater than `cfg_step` sets `step_flag`, in either direction; a difference equal to `cfg_step` does not.
- R7: The first accepted sample after reset, or after `enable` returns high, performs no step comparison.
- R8: `step_flag` stays set until a cycle with `flag_clear`=1; if a new step violation is accepted in that same cycle, the flag stays set.
- R9: Samples that arrive while `enable`=0, and cycles with `smp_valid`=0, change neither flag and do not update the previous sample.
- R10: Both flags change at the first rising clock edge after the accepted sample, and not before.
- R11: `flag_clear` has no effect on `over_flag`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Monitor enable level |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 16 | Unsigned ADC sample |
| cfg_ceiling | input | 16 | Upper limit |
| cfg_margin | input | 16 | Hysteresis subtracted from the limit for release |
| cfg_step | input | 16 | Largest allowed step between consecutive samples |
| flag_clear | input | 1 | One-cycle clear for the step flag |
| over_flag | output | 1 | Over-limit flag with hysteresis |
| step_flag | output | 1 | Sticky rate-of-change flag |

## Verification
Two things can land in the same cycle on the step flag: a clear pulse and a new step violation. The directed part of the bench makes this happen. It first sets the flag, then drives a sample with a large jump in the same cycle as `flag_clear`, and expects the flag to stay set. It then drives a clear with no sample and expects the flag to drop. In the random part, clear pulses come about one cycle in ten, while samples wander around the limit. This makes clears often meet violations, and also meet hysteresis transitions on the other flag. A bench model judges every cycle.

// File: rtl/adc_mon_pkg.sv
package adc_mon_pkg;

   // Decision taken by the limit unit for one accepted sample
   typedef enum logic [1:0] {
      LIM_HOLD    = 2'd0,
      LIM_SET     = 2'd1,
      LIM_RELEASE = 2'd2
   } lim_action_e;

endpackage

// File: rtl/adc_mon_release_calc.sv
module adc_mon_release_calc #(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0] ceiling,
   input  logic [DATA_W-1:0] margin,
   output logic [DATA_W-1:0] release_lvl
);
   initial begin
      if (DATA_W < 2) $error("adc_mon_release_calc: DATA_W must be at least 2");
   end

   logic [DATA_W:0] diff_ext;

   always_comb begin
      diff_ext = {1'b0, ceiling} - {1'b0, margin};
      // borrow out means margin exceeded ceiling: clamp to zero (R5)
      if (diff_ext[DATA_W]) release_lvl = '0;
      else                  release_lvl = diff_ext[DATA_W-1:0];
   end

   always_comb begin
      assert (release_lvl <= ceiling) else $error("p_release_below_ceiling_r5");
   end
endmodule

// File: rtl/adc_mon_limit_unit.sv
module adc_mon_limit_unit
   import adc_mon_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [DATA_W-1:0] sample,
   input  logic [DATA_W-1:0] ceiling,
   input  logic [DATA_W-1:0] release_lvl,
   output logic              over_q
);
   initial begin
      if (DATA_W < 2) $error("adc_mon_limit_unit: DATA_W must be at least 2");
   end

   lim_action_e action;

   always_comb begin
      action = LIM_HOLD;
      if (sample > ceiling)          action = LIM_SET;
      else if (sample < release_lvl) action = LIM_RELEASE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         over_q <= 1'b0;
      end else if (accept) begin
         case (action)
            LIM_SET:     over_q <= 1'b1;
            LIM_RELEASE: over_q <= 1'b0;
            default:     over_q <= over_q;
         endcase
      end
   end

   p_over_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && (sample > ceiling)) |=> over_q);

   p_over_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && (sample < release_lvl) && !(sample > ceiling)) |=> !over_q);

   p_over_band_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && (sample <= ceiling) && (sample >= release_lvl)) |=> $stable(over_q));

   p_over_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !accept |=> $stable(over_q));
endmodule

// File: rtl/adc_mon_delta_unit.sv
module adc_mon_delta_unit #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              accept,
   input  logic [DATA_W-1:0] sample,
   input  logic [DATA_W-1:0] step_lim,
   input  logic              clear,
   output logic              step_q
);
   initial begin
      if (DATA_W < 2) $error("adc_mon_delta_unit: DATA_W must be at least 2");
   end

   logic [DATA_W-1:0] prev_q;
   logic              prev_ok_q;
   logic [DATA_W-1:0] abs_diff;
   logic              violation;

   always_comb begin
      if (sample >= prev_q) abs_diff = sample - prev_q;
      else                  abs_diff = prev_q - sample;
      violation = accept && prev_ok_q && (abs_diff > step_lim);
   end

   // history: the previous sample is held only while the block stays enabled
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q    <= '0;
         prev_ok_q <= 1'b0;
      end else if (accept) begin
         prev_q    <= sample;
         prev_ok_q <= 1'b1;
      end else if (!enable) begin
         prev_ok_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) step_q <= 1'b0;
      else        step_q <= violation | (step_q & ~clear);
   end

   p_step_first_skip_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !prev_ok_q && !step_q) |=> !step_q);

   p_step_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (step_q && !clear) |=> step_q);

   p_step_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (clear && !accept) |=> !step_q);

   p_step_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!accept && !clear) |=> $stable(step_q));

   p_history_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !prev_ok_q);
endmodule

// File: rtl/adc_limit_delta_monitor.sv
module adc_limit_delta_monitor #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              smp_valid,
   input  logic [DATA_W-1:0] smp_data,
   input  logic [DATA_W-1:0] cfg_ceiling,
   input  logic [DATA_W-1:0] cfg_margin,
   input  logic [DATA_W-1:0] cfg_step,
   input  logic              flag_clear,
   output logic              over_flag,
   output logic              step_flag
);
   initial begin
      if (DATA_W < 2 || DATA_W > 32)
         $error("adc_limit_delta_monitor: DATA_W out of range 2..32");
   end

   logic              accept;
   logic [DATA_W-1:0] release_lvl;

   assign accept = smp_valid & enable;

   adc_mon_release_calc #(.DATA_W(DATA_W)) u_release (
      .ceiling    (cfg_ceiling),
      .margin     (cfg_margin),
      .release_lvl(release_lvl)
   );

   adc_mon_limit_unit #(.DATA_W(DATA_W)) u_limit (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept),
      .sample     (smp_data),
      .ceiling    (cfg_ceiling),
      .release_lvl(release_lvl),
      .over_q     (over_flag)
   );

   adc_mon_delta_unit #(.DATA_W(DATA_W)) u_delta (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (enable),
      .accept  (accept),
      .sample  (smp_data),
      .step_lim(cfg_step),
      .clear   (flag_clear),
      .step_q  (step_flag)
   );

   p_clear_no_over_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clear && !accept) |=> $stable(over_flag));

   p_disabled_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable && !flag_clear) |=> ($stable(over_flag) && $stable(step_flag)));
endmodule

// File: tb/adc_limit_delta_monitor_test.sv
module adc_limit_delta_monitor_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic        smp_valid = 1'b0;
   logic [15:0] smp_data = '0;
   logic [15:0] cfg_ceiling = '0;
   logic [15:0] cfg_margin = '0;
   logic [15:0] cfg_step = '0;
   logic        flag_clear = 1'b0;
   logic        over_flag;
   logic        step_flag;

   int n_cmp = 0;
   int n_bad = 0;

   // reference state
   bit        m_over = 0;
   bit        m_step = 0;
   bit        m_have = 0;
   bit [15:0] m_prev = 0;

   always #10 clk = ~clk;  // 50 MHz

   adc_limit_delta_monitor uut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .smp_valid(smp_valid),
      .smp_data(smp_data), .cfg_ceiling(cfg_ceiling), .cfg_margin(cfg_margin),
      .cfg_step(cfg_step), .flag_clear(flag_clear),
      .over_flag(over_flag), .step_flag(step_flag)
   );

   function automatic bit [15:0] f_release(bit [15:0] c, bit [15:0] m);
      return (m >= c) ? 16'd0 : c - m;
   endfunction

   function automatic bit [15:0] f_absdiff(bit [15:0] a, bit [15:0] b);
      return (a >= b) ? a - b : b - a;
   endfunction

   task automatic check(string tag, string what, bit act, bit exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
      end
   endtask

   // one clock of stimulus; inputs driven at the falling edge
   task automatic step(bit v, bit en, bit clr, bit [15:0] s, string tag);
      bit acc;
      bit viol;
      @(negedge clk);
      smp_valid = v; enable = en; flag_clear = clr; smp_data = s;
      #2;
      check("R10", "over before edge", over_flag, m_over);
      check("R10", "step before edge", step_flag, m_step);
      acc  = v && en;
      viol = acc && m_have && (f_absdiff(s, m_prev) > cfg_step);
      m_step = viol || (m_step && !clr);
      if (acc) begin
         if (s > cfg_ceiling) m_over = 1;
         else if (s < f_release(cfg_ceiling, cfg_margin)) m_over = 0;
         m_prev = s;
         m_have = 1;
      end else if (!en) begin
         m_have = 0;
      end
      @(negedge clk);
      check(tag, "over_flag", over_flag, m_over);
      check(tag, "step_flag", step_flag, m_step);
      smp_valid = 0; flag_clear = 0;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      bit [31:0] seed_dummy;
      seed_dummy = $urandom(32'd4711);
      repeat (3) @(negedge clk);
      check("R1", "over after reset", over_flag, 1'b0);
      check("R1", "step after reset", step_flag, 1'b0);
      rst_n = 1;
      cfg_ceiling = 16'd1000; cfg_margin = 16'd100; cfg_step = 16'd50;

      step(1, 1, 0, 16'd1000, "R2_R7");   // equal to limit; first sample, no step test
      step(1, 1, 0, 16'd1001, "R2");      // strictly above: set
      step(1, 1, 0, 16'd980,  "R4");      // band
      step(1, 1, 0, 16'd930,  "R4_R6");   // diff 50 equals step: no error
      step(1, 1, 0, 16'd900,  "R3");      // equal to release: hold
      step(1, 1, 0, 16'd899,  "R3");      // below: release
      step(1, 1, 0, 16'd960,  "R6");      // up 61: error
      step(1, 1, 0, 16'd961,  "R8");      // sticky
      step(0, 1, 1, 16'd0,    "R8");      // clear alone
      step(1, 1, 1, 16'd900,  "R8");      // clear with violation: stays
      step(0, 1, 1, 16'd0,    "R8");
      step(1, 1, 0, 16'd950,  "R6");      // up 50: none
      step(1, 1, 0, 16'd899,  "R6");      // down 51: error
      step(0, 1, 1, 16'd0,    "R8");
      step(1, 0, 0, 16'd5000, "R9");      // disabled: ignored
      step(0, 1, 0, 16'd5000, "R9");      // no strobe: ignored
      step(1, 1, 0, 16'd5000, "R7_R2");   // first after re-enable: no step test
      step(0, 1, 1, 16'd0,    "R11");     // clear leaves over flag
      step(1, 1, 1, 16'd0,    "R3_R8");   // release plus violation with clear
      cfg_ceiling = 16'd100; cfg_margin = 16'd200;
      step(0, 1, 1, 16'd0,    "R8");
      step(1, 1, 0, 16'd101,  "R5");
      step(1, 1, 0, 16'd0,    "R5");      // release saturates at 0: hold
      cfg_margin = 16'd100;
      step(1, 1, 0, 16'd0,    "R5");      // margin equals limit: still 0
      cfg_ceiling = 16'hFFFF; cfg_margin = 16'd0;
      step(1, 1, 0, 16'hFFFF, "R2");      // max value never exceeds max limit

      cfg_ceiling = 16'd1000; cfg_margin = 16'd100; cfg_step = 16'd40;
      for (int i = 0; i < 600; i++) begin
         bit v, en, clr;
         bit [15:0] s;
         if ((i % 100) == 50) begin
            cfg_ceiling = 16'($urandom_range(400, 2000));
            cfg_margin  = 16'($urandom_range(0, 300));
            cfg_step    = 16'($urandom_range(5, 120));
         end
         v   = ($urandom_range(0, 9) < 8);
         en  = ($urandom_range(0, 19) != 0);
         clr = ($urandom_range(0, 9) == 0);
         s   = 16'(int'(cfg_ceiling) - 350 + int'($urandom_range(0, 500)));
         step(v, en, clr, s, "R2_R3_R6_R8_rand");
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule